// File: doc/BRIEF.md
# Serial Peripheral Slave, Phase-0 Framing

This block is the receiving end of a four-wire serial peripheral link. It moves one byte in each direction per frame. An external master drives the select, clock and data-out lines, and the block answers on its own data line. The framing is clock phase 0 only. The incoming line is sampled on the first, third and later odd clock edges of a frame. The outgoing line changes on the even edges, and its first bit is already on the line when select is asserted. Clock polarity and bit order are set by two configuration inputs.

All pin inputs are brought into the system clock domain through a two-stage synchroniser, and clock edges are found by comparing samples. The system clock must run at least four times faster than the serial clock.

- On the parallel side, a write strobe fills the transmit register.
- A receive register holds the last complete byte.
- A sticky done flag marks each finished frame, and a clear pulse resets it.

If select stays low between frames, or rises for fewer system clocks than a programmable minimum, the next frame echoes the byte just received. It does not send the transmit register in that case.

Top module: `spi_cpha0_slave`

## Requirements
- R1: After reset, `rxData` is 0x00, `doneFlag` is 0 and `spiMisoEn` is 0.
- R2: `spiMisoEn` is 0 while select is high and 1 during a frame. It follows select with a delay of three system clocks.
- R3: With phase 0, the first outgoing bit is on `spiMiso` before the first clock edge of a frame. The incoming line is sampled on each leading clock edge, and the outgoing bit changes on each trailing edge.
- R4: `cfgCpol` = 0 means the clock idles low and the leading edge rises. `cfgCpol` = 1 means it idles high and the leading edge falls. The edge numbering is the same in both cases.
- R5: `cfgLsbFirst` = 0 shifts bit 7 first and bit 0 last. `cfgLsbFirst` = 1 shifts bit 0 first. The same order applies on both data lines.
- R6: `rxData` keeps its old value until the 16th clock edge of a frame. Then it takes the whole received byte and `doneFlag` is set.
- R7: `doneFlag` stays set until a `doneClr` pulse. A finishing frame wins over a clear in the same cycle. A byte that completes while the flag is still set overwrites `rxData`.
- R8: If select stays low from one frame into the next, the next frame sends the byte received in the previous frame.
- R9: If select is high for at least `idleMinCnt` system clocks before it falls, the frame sends the transmit register. If it is high for fewer clocks, the frame sends the last received byte.
- R10: A transmit write during a frame does not change the bits sent in that frame. It takes effect at the next qualifying select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| idleMinCnt | input | IDLE_W | Minimum select-high time, in system clocks, for the transmit register to be used |
| txWrEn | input | 1 | Transmit register write strobe |
| txWrData | input | DATA_W | Transmit register write value |
| rxData | output | DATA_W | Last completely received byte |
| doneFlag | output | 1 | Sticky frame-complete flag |
| doneClr | input | 1 | Clear pulse for doneFlag |
| spiSelN | input | 1 | Active-low select from the master |
| spiSck | input | 1 | Serial clock from the master |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master |
| spiMisoEn | output | 1 | Output enable for spiMiso (0 = high impedance) |

## Verification
The hardest case to reach is a short select-high gap. Select must rise and fall again within fewer system clocks than the idle minimum, yet stay high long enough to pass the synchroniser. Otherwise the slave cannot tell it apart from the held-low case. The model master releases select for six system clocks against a minimum of twenty. It then releases for forty clocks before the next frame, so both outcomes of the idle comparison come from the same preceding received byte. A transmit write issued halfway through a frame shows whether the shifter is reloaded only at the select fall.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // control-to-datapath strobes, one cycle wide
  typedef struct packed {
    logic loadTx;   // select fell after a long enough idle: reload shifter
    logic capture;  // leading edge: sample incoming bit
    logic shift;    // trailing edge: shift and present next bit
    logic finish;   // trailing edge number 16: byte complete
  } strobe_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic [IDLE_W-1:0] idleMinCnt,
  input  logic              spiSelN,
  input  logic              spiSck,
  input  logic              spiMosi,
  output strobe_t           strb,
  output logic              selHigh,
  output logic              mosiS
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic selS, sckS, sckPrev, selPrev;
  logic selFall, active, leadEdge, trailEdge;
  logic [CNT_W-1:0] edgeCnt;
  logic [IDLE_W-1:0] idleCnt;

  spi_slv_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({spiSelN, spiSck, spiMosi}),
    .dout({selS, sckS, mosiS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      selPrev <= 1'b1;
    end else begin
      sckPrev <= sckS;
      selPrev <= selS;
    end
  end

  assign selFall   = selPrev & ~selS;
  assign active    = ~selS & ~selFall;
  assign leadEdge  = active & (sckPrev == cfgCpol) & (sckS != cfgCpol);
  assign trailEdge = active & (sckPrev != cfgCpol) & (sckS == cfgCpol);

  // edge counter within a frame, wraps after the last edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (selS || selFall) edgeCnt <= '0;
    else if (leadEdge || trailEdge) edgeCnt <= edgeCnt + 1'b1;
  end

  // select-high duration, saturating; starts saturated so the first frame uses tx
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= IDLE_MAX;
    else if (!selS) idleCnt <= '0;
    else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  always_comb begin
    strb.loadTx  = selFall && (idleCnt >= idleMinCnt);
    strb.capture = leadEdge;
    strb.shift   = trailEdge;
    strb.finish  = trailEdge && (edgeCnt == LAST_EDGE);
  end

  assign selHigh = selS;

  // R3: leading and trailing edges never coincide
  a_r3_edge_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capture, strb.shift}));
  // R2: a deselected slave starts every frame from edge zero
  a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> (edgeCnt == '0));
  // R6: no frame completes while deselected
  a_r6_no_finish_idle: assert property (@(posedge clk) disable iff (!rstN)
    selS |-> !strb.finish);
endmodule

// File: rtl/spi_slv_dpath.sv
module spi_slv_dpath
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              selHigh,
  input  logic              mosiS,
  input  logic              cfgLsbFirst,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              doneClr,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              misoBit,
  output logic              misoEn
);
  logic [DATA_W-1:0] txReg, shReg, shNext, rxReg;
  logic sampleBit, flagQ, misoEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '0;
    else if (txWrEn) txReg <= txWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleBit <= 1'b0;
    else if (strb.capture) sampleBit <= mosiS;
  end

  // one register serves both directions; after eight shifts it holds the received byte
  assign shNext = cfgLsbFirst ? {sampleBit, shReg[DATA_W-1:1]}
                              : {shReg[DATA_W-2:0], sampleBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strb.loadTx) shReg <= txReg;
    else if (strb.shift) shReg <= shNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= '0;
    else if (strb.finish) rxReg <= shNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else if (strb.finish) flagQ <= 1'b1;
    else if (doneClr) flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) misoEnQ <= 1'b0;
    else misoEnQ <= ~selHigh;
  end

  assign misoBit  = cfgLsbFirst ? shReg[0] : shReg[DATA_W-1];
  assign misoEn   = misoEnQ;
  assign rxData   = rxReg;
  assign doneFlag = flagQ;

  // R6: a completed byte always raises the flag
  a_r6_flag_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> doneFlag);
  // R7: a clear without a finishing frame drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !strb.finish) |=> !doneFlag);
  // R6: the receive register moves only on frame completion
  a_r6_rx_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(rxData));
endmodule

// File: rtl/spi_cpha0_slave.sv
module spi_cpha0_slave
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic              cfgLsbFirst,
  input  logic [IDLE_W-1:0] idleMinCnt,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  input  logic              doneClr,
  input  logic              spiSelN,
  input  logic              spiSck,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              spiMisoEn
);
  strobe_t strb;
  logic selHigh, mosiS;

  spi_slv_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .IDLE_W(IDLE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgCpol   (cfgCpol),
    .idleMinCnt(idleMinCnt),
    .spiSelN   (spiSelN),
    .spiSck    (spiSck),
    .spiMosi   (spiMosi),
    .strb      (strb),
    .selHigh   (selHigh),
    .mosiS     (mosiS)
  );

  spi_slv_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .selHigh    (selHigh),
    .mosiS      (mosiS),
    .cfgLsbFirst(cfgLsbFirst),
    .txWrEn     (txWrEn),
    .txWrData   (txWrData),
    .doneClr    (doneClr),
    .rxData     (rxData),
    .doneFlag   (doneFlag),
    .misoBit    (spiMiso),
    .misoEn     (spiMisoEn)
  );

  // R2: output stays disabled while select has been high for several clocks
  a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (spiSelN && $past(spiSelN, 1) && $past(spiSelN, 2) && $past(spiSelN, 3))
      |-> !spiMisoEn);
endmodule

// File: tb/tb_spi_cpha0_slave.sv
module tb_spi_cpha0_slave;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgCpol = 1'b0, cfgLsbFirst = 1'b0;
  logic [7:0] idleMinCnt = 8'd16;
  logic txWrEn = 1'b0, doneClr = 1'b0;
  logic [7:0] txWrData = '0;
  logic [7:0] rxData;
  logic doneFlag, spiMiso, spiMisoEn;
  logic spiSelN = 1'b1, spiSck = 1'b0, spiMosi = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_cpha0_slave dut (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgLsbFirst(cfgLsbFirst),
    .idleMinCnt(idleMinCnt), .txWrEn(txWrEn), .txWrData(txWrData),
    .rxData(rxData), .doneFlag(doneFlag), .doneClr(doneClr),
    .spiSelN(spiSelN), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiMisoEn(spiMisoEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeTx(input logic [7:0] v);
    txWrEn = 1'b1; txWrData = v; tick(1); txWrEn = 1'b0;
  endtask

  task automatic setMode(input logic cpol, input logic lsb);
    spiSelN = 1'b1; cfgCpol = cpol; cfgLsbFirst = lsb; spiSck = cpol;
    tick(10);
  endtask

  // model master: one byte, phase 0; optional transmit write halfway through
  task automatic frame(input logic [7:0] mo, output logic [7:0] mi, input bit keepSel,
                       input bit wrMid, input logic [7:0] wrVal);
    logic [7:0] rxBefore;
    rxBefore = rxData;
    spiSelN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = cfgLsbFirst ? i : 7 - i;
      spiMosi = mo[idx];
      tick(HALF);
      mi[idx] = spiMiso;
      if (i == 0) check("R2 enable in frame", 32'(spiMisoEn), 32'd1);
      spiSck = ~cfgCpol;
      if (wrMid && i == 3) begin
        writeTx(wrVal); tick(HALF - 1);
      end else tick(HALF);
      if (i == 7) check("R6 rx held before edge 16", 32'(rxData), 32'(rxBefore));
      spiSck = cfgCpol;
    end
    tick(6);
    if (!keepSel) spiSelN = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 rxData", 32'(rxData), 32'h0);
    check("R1 doneFlag", 32'(doneFlag), 32'h0);
    check("R1/R2 misoEn", 32'(spiMisoEn), 32'h0);
  endtask

  task automatic t_modes;
    logic [7:0] mi;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] tx, mo;
      tx = 8'h35 + 8'(k) * 8'h42;
      mo = 8'h6C ^ (8'(k) * 8'h1B);
      setMode(k[1], k[0]);
      writeTx(tx);
      doneClr = 1'b1; tick(1); doneClr = 1'b0;
      tick(40);
      frame(mo, mi, 0, 0, 8'h00);
      check("R3/R4/R5 miso byte", 32'(mi), 32'(tx));
      check("R4/R5 rx byte", 32'(rxData), 32'(mo));
      check("R6 flag set", 32'(doneFlag), 32'd1);
      tick(5);
      check("R2 disabled after release", 32'(spiMisoEn), 32'd0);
    end
  endtask

  task automatic t_backtoback;
    logic [7:0] mi;
    setMode(1'b0, 1'b0);
    writeTx(8'h5A); tick(40);
    frame(8'h3C, mi, 1, 0, 8'h00);
    check("R8 first frame tx", 32'(mi), 32'h5A);
    frame(8'hE1, mi, 1, 0, 8'h00);
    check("R8 echo of previous byte", 32'(mi), 32'h3C);
    frame(8'h07, mi, 0, 0, 8'h00);
    check("R8 second echo", 32'(mi), 32'hE1);
  endtask

  task automatic t_idle;
    logic [7:0] mi;
    idleMinCnt = 8'd20;
    writeTx(8'h96);
    tick(5);
    frame(8'h48, mi, 0, 0, 8'h00);
    check("R9 short idle echoes", 32'(mi), 32'h07);
    tick(40);
    frame(8'h2B, mi, 0, 0, 8'h00);
    check("R9 long idle sends tx", 32'(mi), 32'h96);
    idleMinCnt = 8'd16;
  endtask

  task automatic t_flag;
    logic [7:0] mi;
    tick(50);
    check("R7 flag sticky", 32'(doneFlag), 32'd1);
    doneClr = 1'b1; tick(1); doneClr = 1'b0; tick(1);
    check("R7 flag cleared", 32'(doneFlag), 32'd0);
    tick(30);
    frame(8'hD4, mi, 0, 0, 8'h00);
    check("R7 flag set again", 32'(doneFlag), 32'd1);
    tick(30);
    frame(8'h81, mi, 0, 0, 8'h00);
    check("R7 overwrite with flag set", 32'(rxData), 32'h81);
  endtask

  task automatic t_txmid;
    logic [7:0] mi;
    setMode(1'b1, 1'b1);
    writeTx(8'hC6); tick(40);
    frame(8'h19, mi, 0, 1, 8'h3F);
    check("R10 mid-frame write ignored", 32'(mi), 32'hC6);
    tick(40);
    frame(8'h19, mi, 0, 0, 8'h00);
    check("R10 write used next frame", 32'(mi), 32'h3F);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(3);
    t_reset();
    t_modes();
    t_backtoback();
    t_idle();
    t_flag();
    t_txmid();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule